// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status-register front end of a serial flash. It watches an SPI bus as a slave in either clock polarity (idle-low or idle-high clock, data sampled on the rising clock edge, most significant bit first). It decodes three commands: write enable, write status and read status. It holds the block-protect field and the lock bit that the array logic uses to refuse writes to protected regions.

A status write takes effect only when chip enable returns high exactly 8 or 16 data bits after the opcode. It also needs the write-enable latch to be set. The lock bit works together with the active-low write-protect pin. While the pin is low, a set lock freezes the register. A clear lock may still be set in that state, but never cleared. Read status streams the live status byte on the serial output for as long as the clock runs. The busy flag from an external program/erase engine appears in bit 0.

All SPI inputs are sampled by the system clock. SCK must therefore stay in each level for at least two system clock cycles.

Top module: `sfsr_top`

## Requirements
- R1: After reset, bp_o is 0, bpl_o is 0, so_oe_o is 0, and a status read returns 00h while busy_i is low.
- R2: Commands work in both SPI mode 0 (SCK idle low) and mode 3 (SCK idle high). SI is sampled on rising SCK, and every byte is shifted MSB first.
- R3: Opcode 06h sets the write-enable latch (status bit 1) only when chip enable rises after exactly 8 bits. Opcodes other than 06h, 01h and 05h change nothing.
- R4: Opcode 01h followed by a data byte loads status bits 5..2 (BP field, bp_o[3:0]) and bit 7 (lock, bpl_o) from the same bit positions of that byte. Data bits 6, 1 and 0 have no effect.
- R5: A status write commits only if chip enable rises after exactly 8 or 16 data bits. With 16 bits, the second byte is ignored. Any other count leaves BP and lock unchanged.
- R6: A status write with the write-enable latch clear changes nothing.
- R7: The write-enable latch is clear after any status write whose opcode was fully received, whether the write committed or not.
- R8: With wp_ni low and the lock at 1, a status write changes nothing.
- R9: With wp_ni low and the lock at 0, one status write may set the lock and change BP together. While wp_ni is low, the lock is never cleared.
- R10: With wp_ni high, a status write can change BP and clear or set the lock freely.
- R11: After opcode 05h, SO carries the status byte MSB first, with this layout: bit0 busy, bit1 write-enable latch, bits 5..2 BP, bit6 0, bit7 lock. The byte repeats until chip enable rises.
- R12: Status reads are accepted while busy_i is high, and bit 0 reflects busy_i.
- R13: so_oe_o is high only while a status read is streaming. It is low one system cycle after chip enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip enable |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Active-low hardware write protect |
| busy_i | input | 1 | Program/erase in progress flag |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| bp_o | output | 4 | Block-protect field to array logic |
| bpl_o | output | 1 | Status lock bit |

## Verification
A wrong bit counter or opcode latch shows up at the commit point. bp_o and bpl_o either change after a transfer of the wrong length or fail to change after an exact 8- or 16-bit one, and this is visible one system cycle after chip enable rises. A stale write-enable latch shows up as bit 1 in the next status read, or as a status write that commits without a preceding write enable. A misaligned output index shows up in the first bit of a status read as a rotated byte. A missed reload at the byte boundary shows up in the second byte as a wrong busy value.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam int BUSY_POS = 0;
  localparam int WEL_POS  = 1;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 4;
  localparam int LOCK_POS = 7;
endpackage

// File: rtl/sfsr_rx.sv
module sfsr_rx #(
  parameter int MAX_BITS = 31,
  localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             si_i,
  output logic             cs_rise_o,
  output logic             sck_fall_o,
  output logic             read_start_o,
  output logic [7:0]       opcode_o,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] cnt_o
);
  import sfsr_pkg::*;

  logic       sck_q, cs_q, sck_rise;
  logic [7:0] shift_q, next_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign sck_rise   = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall_o = ~sck_i & sck_q & ~cs_ni;
  assign cs_rise_o  = cs_ni & ~cs_q;
  assign next_byte  = {shift_q[6:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      cnt_o    <= '0;
      opcode_o <= '0;
      data_o   <= '0;
    end else if (cs_ni) begin
      cnt_o    <= '0;
      opcode_o <= '0;
    end else if (sck_rise) begin
      shift_q <= next_byte;
      if (cnt_o != CNT_W'(MAX_BITS)) cnt_o <= cnt_o + 1'b1;
      if (cnt_o == CNT_W'(7))  opcode_o <= next_byte;
      if (cnt_o == CNT_W'(15)) data_o   <= next_byte;
    end
  end

  assign read_start_o = sck_rise && (cnt_o == CNT_W'(7)) && (next_byte == OP_RDSR);

  // R5
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni)) |-> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/sfsr_regs.sv
module sfsr_regs #(
  parameter int MAX_BITS = 31,
  localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_rise_i,
  input  logic [7:0]               opcode_i,
  input  logic [7:0]               data_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     wp_ni,
  input  logic                     busy_i,
  output logic [7:0]               status_o,
  output logic [sfsr_pkg::BP_W-1:0] bp_o,
  output logic                     bpl_o
);
  import sfsr_pkg::*;

  logic wel_q, wren_ok, wrsr_seen, len_ok, frozen, wrsr_do;
  logic unused_bits;

  assign unused_bits = ^{data_i[6], data_i[1:0]};

  assign wren_ok   = cs_rise_i && opcode_i == OP_WREN && cnt_i == CNT_W'(8);
  assign wrsr_seen = cs_rise_i && opcode_i == OP_WRSR && cnt_i >= CNT_W'(8);
  assign len_ok    = cnt_i == CNT_W'(16) || cnt_i == CNT_W'(24);
  assign frozen    = ~wp_ni & bpl_o;
  assign wrsr_do   = wrsr_seen && len_ok && wel_q && !frozen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      bp_o  <= '0;
      bpl_o <= 1'b0;
    end else begin
      if (wren_ok)        wel_q <= 1'b1;
      else if (wrsr_seen) wel_q <= 1'b0;
      if (wrsr_do) begin
        bp_o  <= data_i[BP_LSB +: BP_W];
        // pin low: lock may only go up
        bpl_o <= wp_ni ? data_i[LOCK_POS] : (bpl_o | data_i[LOCK_POS]);
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[BUSY_POS] = busy_i;
    status_o[WEL_POS]  = wel_q;
    status_o[BP_LSB +: BP_W] = bp_o;
    status_o[LOCK_POS] = bpl_o;
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!wp_ni && bpl_o) |-> bpl_o);
  // R5
  bp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_rise_i) |-> ($stable(bp_o) && $stable(bpl_o)));
  // R7
  wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_rise_i && opcode_i == OP_WRSR && cnt_i >= CNT_W'(8)) |-> !wel_q);
endmodule

// File: rtl/sfsr_tx.sv
module sfsr_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_fall_i,
  input  logic       read_start_i,
  input  logic [7:0] status_i,
  output logic       so_o,
  output logic       so_oe_o
);
  logic       reading_q, pend_q;
  logic [2:0] idx_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reading_q <= 1'b0;
      pend_q    <= 1'b0;
      idx_q     <= 3'd7;
      byte_q    <= '0;
    end else if (cs_ni) begin
      reading_q <= 1'b0;
      pend_q    <= 1'b0;
    end else if (read_start_i) begin
      reading_q <= 1'b1;
      pend_q    <= 1'b1;
      idx_q     <= 3'd7;
      byte_q    <= status_i;
    end else if (reading_q && sck_fall_i) begin
      // falling edge right after the opcode keeps bit 7 on the line
      if (pend_q) pend_q <= 1'b0;
      else if (idx_q == 3'd0) begin
        idx_q  <= 3'd7;
        byte_q <= status_i;
      end else idx_q <= idx_q - 3'd1;
    end
  end

  assign so_oe_o = reading_q;
  assign so_o    = reading_q & byte_q[idx_q];

  // R13
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !so_oe_o);
  // R11
  start_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(read_start_i && !cs_ni) |-> (so_oe_o && idx_q == 3'd7));
endmodule

// File: rtl/sfsr_top.sv
module sfsr_top #(
  parameter int MAX_BITS = 31
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       wp_ni,
  input  logic       busy_i,
  output logic       so_o,
  output logic       so_oe_o,
  output logic [3:0] bp_o,
  output logic       bpl_o
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  logic             cs_rise, sck_fall, read_start;
  logic [7:0]       opcode, data, status;
  logic [CNT_W-1:0] cnt;

  sfsr_rx #(.MAX_BITS(MAX_BITS)) i_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_rise_o(cs_rise), .sck_fall_o(sck_fall), .read_start_o(read_start),
    .opcode_o(opcode), .data_o(data), .cnt_o(cnt)
  );

  sfsr_regs #(.MAX_BITS(MAX_BITS)) i_regs (
    .clk_i, .rst_ni, .cs_rise_i(cs_rise), .opcode_i(opcode), .data_i(data),
    .cnt_i(cnt), .wp_ni, .busy_i, .status_o(status), .bp_o, .bpl_o
  );

  sfsr_tx i_tx (
    .clk_i, .rst_ni, .cs_ni, .sck_fall_i(sck_fall), .read_start_i(read_start),
    .status_i(status), .so_o, .so_oe_o
  );
endmodule

// File: tb/test_sfsr_top.sv
`timescale 1ns/1ps
module test_sfsr_top;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic so, so_oe, bpl;
  logic [3:0] bp;
  logic mode3 = 1'b0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sfsr_top i_sfsr_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .wp_ni(wp_n), .busy_i(busy), .so_o(so), .so_oe_o(so_oe), .bp_o(bp), .bpl_o(bpl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic cs_low();
    sck = mode3;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_high();
    if (!mode3) begin
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r, output logic oe);
    sck = 1'b0;
    si  = b;
    repeat (H) @(negedge clk);
    r  = so;
    oe = so_oe;
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r, oe;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r, oe);
  endtask

  // opcode, then nbits taken from the top of d
  task automatic cmd(input logic [7:0] op, input logic [15:0] d, input int nbits);
    logic r, oe;
    cs_low();
    send_byte(op);
    for (int i = 0; i < nbits; i++) bit_x(d[15-i], r, oe);
    cs_high();
  endtask

  task automatic wren();
    cmd(8'h06, 16'h0, 0);
  endtask

  task automatic wrsr(input logic [7:0] v);
    cmd(8'h01, {v, 8'h00}, 8);
  endtask

  task automatic read_stat(input int nbytes, input logic [7:0] exp, input string tag);
    logic r, oe;
    logic [7:0] got;
    logic oe_all;
    cs_low();
    send_byte(8'h05);
    oe_all = 1'b1;
    for (int n = 0; n < nbytes; n++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_x(1'b0, r, oe);
        got[i] = r;
        oe_all &= oe;
      end
      chk(tag, got, exp);
    end
    chk("R13 oe during read", {7'd0, oe_all}, 8'h01);
    cs_high();
    chk("R13 oe after read", {7'd0, so_oe}, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 bp", {4'd0, bp}, 8'h00);
    chk("R1 bpl", {7'd0, bpl}, 8'h00);
    chk("R1 oe", {7'd0, so_oe}, 8'h00);
    read_stat(1, 8'h00, "R1 status");
  endtask

  task automatic t_wren();
    mode3 = 1'b1;
    wren();
    mode3 = 1'b0;
    read_stat(2, 8'h02, "R2 R3 wren mode3 read mode0");
    cmd(8'h9F, 16'h0, 0);
    read_stat(1, 8'h02, "R3 other opcode");
    cmd(8'h01, 16'h0, 0);
    wren();
    cmd(8'h01, 16'h0, 0);
    cmd(8'h06, 16'hFF00, 8);
    read_stat(1, 8'h00, "R3 wren 16 bits rejected");
  endtask

  task automatic t_wrsr();
    wren();
    wrsr(8'hD7);
    chk("R4 bp", {4'd0, bp}, 8'h05);
    chk("R4 bpl", {7'd0, bpl}, 8'h01);
    read_stat(1, 8'h94, "R4 R7 status");
    mode3 = 1'b1;
    wren();
    wrsr(8'h00);
    read_stat(1, 8'h00, "R10 R2 clear lock wp high");
    mode3 = 1'b0;
  endtask

  task automatic t_len();
    wren();
    cmd(8'h01, 16'h3C00, 7);
    read_stat(1, 8'h00, "R5 R7 7 bits");
    wren();
    cmd(8'h01, 16'h3C80, 9);
    read_stat(1, 8'h00, "R5 9 bits");
    wren();
    cmd(8'h01, 16'h08FF, 16);
    chk("R5 16 bits bp", {4'd0, bp}, 8'h02);
    read_stat(1, 8'h08, "R5 16 bits second byte ignored");
    wren();
    cmd(8'h01, 16'h3C00, 0);
    read_stat(1, 8'h08, "R5 R7 opcode only");
  endtask

  task automatic t_no_wel();
    wrsr(8'h3C);
    read_stat(1, 8'h08, "R6 no wel");
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    wren();
    wrsr(8'h84);
    chk("R9 set lock bpl", {7'd0, bpl}, 8'h01);
    read_stat(1, 8'h84, "R9 set lock and bp");
    wren();
    wrsr(8'h00);
    chk("R8 bpl held", {7'd0, bpl}, 8'h01);
    read_stat(1, 8'h84, "R8 frozen");
    wp_n = 1'b1;
    wren();
    wrsr(8'h00);
    read_stat(1, 8'h00, "R10 unlock");
  endtask

  task automatic t_busy();
    busy = 1'b1;
    read_stat(3, 8'h01, "R12 busy");
    mode3 = 1'b1;
    wren();
    read_stat(2, 8'h03, "R12 R11 busy wel mode3");
    mode3 = 1'b0;
    busy = 1'b0;
    read_stat(1, 8'h02, "R12 busy low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wren();
    t_wrsr();
    t_len();
    t_no_wel();
    t_wp();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule